// File: doc/BRIEF.md
# Multi-Channel Gamma Correction Table

This block is the colour-correction stage of a display compositor that drives several outputs. Each output channel has three 256-entry, 8-bit curves, one each for red, green and blue. All of the curves sit in a single packed table memory. Software fills the table through two registers. The first is a pointer register that holds an entry index, an auto-advance flag and a keep-powered flag. The second is a data window that reads or writes the entry the pointer selects.

Each channel carries a stream of 24-bit RGB pixels with a valid strobe. When that channel's correction enable is set, every component is replaced by the matching entry of its own curve. When the enable is clear, the pixel passes through unchanged. In both cases the result appears one clock later.

The table memory is powered only while at least one channel uses it, or while the keep-powered flag is set. When it powers down, its contents are lost. They read back as zero, and a `lut_valid` indication drops until software writes the table again.

Top module: `gamma_lut_top`

## Requirements
- R1: After reset the pointer is 0, auto-advance and keep-powered are clear, every channel's correction is disabled, `sram_en`, `lut_valid` and every `pix_vld_out` bit are 0, and register reads return 0.
- R2: A write to offset 0x78 loads the entry index from bits 11:0, auto-advance from bit 31 and keep-powered from bit 30. A read of 0x78 returns those three fields in the same positions, with all other bits 0.
- R3: A write to offset 0xE0 stores bits 7:0 at the entry the pointer selects. With auto-advance set, the pointer then moves up by one. With auto-advance clear, the pointer stays where it is.
- R4: With auto-advance set, a data write at the last entry (index 2303 for three channels) returns the pointer to 0.
- R5: A read of offset 0xE0 returns the selected entry in bits 7:0 on `reg_rdata` one clock after the strobe, and it never moves the pointer.
- R6: Entry index = channel × 768 + component × 256 + value, where component 0 is red, 1 is green and 2 is blue.
- R7: The enable for channel c is bit 0 of the register at offset 0x40 + 4·c, and that register reads back the same bit. With the enable set, a valid pixel {R[23:16], G[15:8], B[7:0]} leaves as the three curve entries one clock later.
- R8: With the enable clear, a valid pixel leaves unchanged one clock later. `pix_vld_out` follows `pix_vld_in` one clock later. `pix_out` holds its value while no pixel is valid.
- R9: `sram_en` is high exactly when some channel's enable or keep-powered is set. While it is low, every entry is wiped to 0 and data writes are dropped. With keep-powered set, the contents survive all enables being cleared.
- R10: `lut_valid` rises after a data write to an in-range entry while powered, and it falls once the memory powers down.
- R11: When a data write and a pixel lookup hit the same entry in the same clock, the lookup returns the value from before the write.
- R12: A data write with the pointer beyond the last entry is dropped, and a data read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one clock after `reg_rd` |
| pix_in | input | NUM_CH×24 | Per-channel input pixel {R,G,B} |
| pix_vld_in | input | NUM_CH | Per-channel input pixel valid |
| pix_out | output | NUM_CH×24 | Per-channel corrected pixel |
| pix_vld_out | output | NUM_CH | Per-channel output pixel valid |
| sram_en | output | 1 | Table memory powered |
| lut_valid | output | 1 | Table written since the last power-down |

## Verification
The register port and the pixel path can touch the same table entry in one clock: a data-window write to an entry can coincide with a lookup of that entry by a channel's pixel. The bench provokes this by first parking the pointer on a red entry of channel 2 with auto-advance off. In a single cycle it then raises the data write and a pixel whose red component indexes that entry. It judges the result by requiring that the corrected pixel carry the entry's previous value, and that the very next pixel with the same component carry the newly written one.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam int unsigned COMPS = 3;
  localparam int unsigned REG_W = 32;
  localparam logic [7:0] OFS_PTR  = 8'h78;
  localparam logic [7:0] OFS_WIN  = 8'hE0;
  localparam logic [7:0] OFS_CFG0 = 8'h40;
  localparam int unsigned BIT_AUTOINC = 31;
  localparam int unsigned BIT_KEEPON  = 30;
endpackage

// File: rtl/gamma_regs.sv
module gamma_regs
  import gamma_lut_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = 12,
  parameter int unsigned TOTAL  = 2304
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [DW-1:0]     ent_rdata,
  output logic [AW-1:0]     ptr,
  output logic              data_wr,
  output logic [DW-1:0]     data_wdata,
  output logic [NUM_CH-1:0] gam_en,
  output logic              keep_on,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam logic [AW-1:0] LAST = AW'(TOTAL - 1);

  logic [AW-1:0]     ptr_q, ptr_d;
  logic              inc_q, inc_d;
  logic              keep_q, keep_d;
  logic [NUM_CH-1:0] en_q, en_d;
  logic [REG_W-1:0]  rdata_q, rdata_d;
  logic              ptr_wr;
  logic              unused_bits;

  assign ptr_wr      = reg_wr && (reg_addr == OFS_PTR);
  assign data_wr     = reg_wr && (reg_addr == OFS_WIN);
  assign data_wdata  = reg_wdata[DW-1:0];
  assign unused_bits = ^reg_wdata[29:AW];

  always_comb begin
    ptr_d   = ptr_q;
    inc_d   = inc_q;
    keep_d  = keep_q;
    en_d    = en_q;
    rdata_d = rdata_q;
    if (ptr_wr) begin
      ptr_d  = reg_wdata[AW-1:0];
      inc_d  = reg_wdata[BIT_AUTOINC];
      keep_d = reg_wdata[BIT_KEEPON];
    end else if (data_wr && inc_q) begin
      ptr_d = (ptr_q >= LAST) ? '0 : ptr_q + AW'(1);
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_wr && (reg_addr == 8'(OFS_CFG0 + 8'(4 * c)))) en_d[c] = reg_wdata[0];
    end
    if (reg_rd) begin
      rdata_d = '0;
      if (reg_addr == OFS_PTR) begin
        rdata_d[BIT_AUTOINC] = inc_q;
        rdata_d[BIT_KEEPON]  = keep_q;
        rdata_d[AW-1:0]      = ptr_q;
      end else if (reg_addr == OFS_WIN) begin
        rdata_d[DW-1:0] = ent_rdata;
      end else begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (reg_addr == 8'(OFS_CFG0 + 8'(4 * c))) rdata_d[0] = en_q[c];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      inc_q   <= 1'b0;
      keep_q  <= 1'b0;
      en_q    <= '0;
      rdata_q <= '0;
    end else begin
      ptr_q   <= ptr_d;
      inc_q   <= inc_d;
      keep_q  <= keep_d;
      en_q    <= en_d;
      rdata_q <= rdata_d;
    end
  end

  assign ptr       = ptr_q;
  assign gam_en    = en_q;
  assign keep_on   = keep_q;
  assign reg_rdata = rdata_q;

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && inc_q && ptr_q < LAST) |=> ptr_q == $past(ptr_q) + AW'(1));
  // R3
  ptr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !inc_q) |=> $stable(ptr_q));
  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && inc_q && ptr_q == LAST) |=> ptr_q == '0);
  // R5
  read_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr) |=> $stable(ptr_q));
endmodule

// File: rtl/gamma_table_mem.sv
module gamma_table_mem #(
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 12,
  parameter int unsigned TOTAL = 2304,
  parameter int unsigned NRD   = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sram_on,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0][DW-1:0]  rd_data,
  output logic                    lut_valid
);
  localparam logic [AW-1:0] LAST = AW'(TOTAL - 1);

  logic [DW-1:0] mem_q [TOTAL];
  logic          wr_ok;
  logic          vld_q, vld_d;

  assign wr_ok = sram_on && wr_en && (wr_addr <= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) mem_q[i] <= '0;
    end else if (!sram_on) begin
      for (int i = 0; i < TOTAL; i++) mem_q[i] <= '0;
    end else if (wr_ok) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r] = (rd_addr[r] <= LAST) ? mem_q[rd_addr[r]] : '0;
  end

  always_comb begin
    vld_d = vld_q;
    if (!sram_on)   vld_d = 1'b0;
    else if (wr_ok) vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign lut_valid = vld_q;

  // R9
  wipe_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_on |=> !lut_valid);
  // R10
  valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_on && wr_en && wr_addr <= LAST) |=> lut_valid);
endmodule

// File: rtl/gamma_pixel_ch.sv
module gamma_pixel_ch
  import gamma_lut_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 12,
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned CH      = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [COMPS*DW-1:0]        pix_in,
  input  logic                       vld_in,
  output logic [COMPS-1:0][AW-1:0]   lut_addr,
  input  logic [COMPS-1:0][DW-1:0]   lut_data,
  output logic [COMPS*DW-1:0]        pix_out,
  output logic                       vld_out
);
  localparam int unsigned PW = COMPS * DW;
  localparam logic [AW-1:0] BASE = AW'(CH * COMPS * ENTRIES);

  logic [PW-1:0] pix_q, pix_d, mapped;
  logic          vld_q;

  for (genvar c = 0; c < COMPS; c++) begin : g_comp
    assign lut_addr[c] = BASE + AW'(c * ENTRIES) + AW'(pix_in[(COMPS-1-c)*DW +: DW]);
    assign mapped[(COMPS-1-c)*DW +: DW] = lut_data[c];
  end

  always_comb begin
    pix_d = pix_q;
    if (vld_in) pix_d = en ? mapped : pix_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
      vld_q <= 1'b0;
    end else begin
      pix_q <= pix_d;
      vld_q <= vld_in;
    end
  end

  assign pix_out = pix_q;
  assign vld_out = vld_q;

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_in && !en) |=> pix_out == $past(pix_in));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_in |=> $stable(pix_out));
  // R8
  vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_in |=> vld_out);
  // R8
  vld_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_in |=> !vld_out);
endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
  import gamma_lut_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned DW     = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_wr,
  input  logic                            reg_rd,
  input  logic [7:0]                      reg_addr,
  input  logic [31:0]                     reg_wdata,
  output logic [31:0]                     reg_rdata,
  input  logic [NUM_CH-1:0][3*DW-1:0]     pix_in,
  input  logic [NUM_CH-1:0]               pix_vld_in,
  output logic [NUM_CH-1:0][3*DW-1:0]     pix_out,
  output logic [NUM_CH-1:0]               pix_vld_out,
  output logic                            sram_en,
  output logic                            lut_valid
);
  localparam int unsigned ENTRIES = 1 << DW;
  localparam int unsigned TOTAL   = NUM_CH * COMPS * ENTRIES;
  localparam int unsigned AW      = $clog2(TOTAL);
  localparam int unsigned NRD     = NUM_CH * COMPS + 1;

  logic [1:0]               rst_sync_q;
  logic                     rst_n_i;
  logic [AW-1:0]            ptr;
  logic                     data_wr;
  logic [DW-1:0]            data_wdata;
  logic [NUM_CH-1:0]        gam_en;
  logic                     keep_on;
  logic [NRD-1:0][AW-1:0]   rd_addr;
  logic [NRD-1:0][DW-1:0]   rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign sram_en = (|gam_en) || keep_on;
  assign rd_addr[NRD-1] = ptr;

  gamma_regs #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW), .TOTAL(TOTAL)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .ent_rdata  (rd_data[NRD-1]),
    .ptr        (ptr),
    .data_wr    (data_wr),
    .data_wdata (data_wdata),
    .gam_en     (gam_en),
    .keep_on    (keep_on),
    .reg_rdata  (reg_rdata)
  );

  gamma_table_mem #(.DW(DW), .AW(AW), .TOTAL(TOTAL), .NRD(NRD)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .sram_on   (sram_en),
    .wr_en     (data_wr),
    .wr_addr   (ptr),
    .wr_data   (data_wdata),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .lut_valid (lut_valid)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    gamma_pixel_ch #(.DW(DW), .AW(AW), .ENTRIES(ENTRIES), .CH(ch)) u_pix (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .en       (gam_en[ch]),
      .pix_in   (pix_in[ch]),
      .vld_in   (pix_vld_in[ch]),
      .lut_addr (rd_addr[ch*COMPS +: COMPS]),
      .lut_data (rd_data[ch*COMPS +: COMPS]),
      .pix_out  (pix_out[ch]),
      .vld_out  (pix_vld_out[ch])
    );
  end
endmodule

// File: tb/gamma_lut_top_tb.sv
module gamma_lut_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 3;
  localparam int DW = 8;
  localparam int TOTAL = NUM_CH * 3 * 256;

  logic clk, rst_n, reg_wr, reg_rd;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [NUM_CH-1:0][23:0] pix_in, pix_out;
  logic [NUM_CH-1:0] pix_vld_in, pix_vld_out;
  logic sram_en, lut_valid;

  int n_chk = 0;
  int n_fail = 0;

  gamma_lut_top #(.NUM_CH(NUM_CH), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_in(pix_in), .pix_vld_in(pix_vld_in), .pix_out(pix_out),
    .pix_vld_out(pix_vld_out), .sram_en(sram_en), .lut_valid(lut_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed { logic [1:0] ch; logic [23:0] pix; } vec_t;
  localparam vec_t VECS [8] = '{
    '{2'd0, 24'h000000}, '{2'd0, 24'hFFFFFF}, '{2'd1, 24'h123456},
    '{2'd1, 24'h80FF01}, '{2'd2, 24'hA55A3C}, '{2'd2, 24'h010203},
    '{2'd0, 24'h7F8081}, '{2'd1, 24'hFE00EF}
  };

  function automatic logic [7:0] tval(int ch, int comp, int i);
    return 8'((i ^ 'h5A) + ch * 37 + comp * 101);
  endfunction

  function automatic logic [23:0] remap(int ch, logic [23:0] p);
    return {tval(ch, 0, int'(p[23:16])), tval(ch, 1, int'(p[15:8])), tval(ch, 2, int'(p[7:0]))};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic drive_pix(int ch, logic [23:0] p);
    @(negedge clk);
    pix_in[ch] = p; pix_vld_in[ch] = 1'b1;
    @(negedge clk);
    pix_vld_in[ch] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    pix_in = '0; pix_vld_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 sram_en", {31'b0, sram_en}, 32'd0);
    check("R1 lut_valid", {31'b0, lut_valid}, 32'd0);
    check("R1 pix_vld_out", {29'b0, pix_vld_out}, 32'd0);
    reg_read(8'h78, rd); check("R1 ptr reg", rd, 32'd0);

    // R9 write while powered down is dropped; R10 valid stays low
    reg_write(8'h78, 32'd0);
    reg_write(8'hE0, 32'h55);
    reg_write(8'h40, 32'd1);
    check("R9 sram_en on", {31'b0, sram_en}, 32'd1);
    reg_read(8'hE0, rd); check("R9 dropped write", rd, 32'd0);
    check("R10 not valid", {31'b0, lut_valid}, 32'd0);

    // R6 load every curve with auto-advance
    reg_write(8'h78, 32'h8000_0000);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'hE0;
    for (int ch = 0; ch < NUM_CH; ch++)
      for (int comp = 0; comp < 3; comp++)
        for (int i = 0; i < 256; i++) begin
          reg_wdata = {24'b0, tval(ch, comp, i)};
          @(negedge clk);
        end
    reg_wr = 1'b0;
    check("R10 valid after load", {31'b0, lut_valid}, 32'd1);
    reg_read(8'h78, rd); check("R4 R2 ptr wrapped after load", rd, 32'h8000_0000);

    // R7 enables and readback
    reg_write(8'h44, 32'd1);
    reg_write(8'h48, 32'd1);
    reg_read(8'h44, rd); check("R7 cfg readback", rd, 32'd1);

    // R6 R7 vector table
    for (int v = 0; v < 8; v++) begin
      drive_pix(int'(VECS[v].ch), VECS[v].pix);
      check("R6 R7 remap", {8'b0, pix_out[VECS[v].ch]}, {8'b0, remap(int'(VECS[v].ch), VECS[v].pix)});
      check("R8 vld_out", {31'b0, pix_vld_out[VECS[v].ch]}, 32'd1);
    end

    // R5 read of window, pointer unchanged
    reg_write(8'h78, 32'(768 + 256 + 5));
    reg_read(8'hE0, rd); check("R5 R6 window read", rd, {24'b0, tval(1, 1, 5)});
    reg_read(8'hE0, rd); check("R5 second read same entry", rd, {24'b0, tval(1, 1, 5)});
    reg_read(8'h78, rd); check("R5 R2 ptr not moved", rd, 32'(768 + 256 + 5));

    // R3 fixed pointer
    reg_write(8'hE0, 32'hFFFF_FF11);
    reg_write(8'hE0, 32'h12);
    reg_read(8'hE0, rd); check("R3 fixed ptr overwrite", rd, 32'h12);

    // R3 auto-advance
    reg_write(8'h78, 32'h8000_000A);
    reg_write(8'hE0, 32'hA1);
    reg_write(8'hE0, 32'hA2);
    reg_read(8'h78, rd); check("R3 ptr advanced", rd, 32'h8000_000C);
    reg_write(8'h78, 32'h0000_000B);
    reg_read(8'hE0, rd); check("R3 advanced data", rd, 32'hA2);

    // R4 wrap at last entry
    reg_write(8'h78, 32'h8000_0000 | 32'(TOTAL - 1));
    reg_write(8'hE0, 32'h77);
    reg_read(8'h78, rd); check("R4 wrap to zero", rd, 32'h8000_0000);
    reg_write(8'h78, 32'(TOTAL - 1));
    reg_read(8'hE0, rd); check("R4 last entry data", rd, 32'h77);

    // R11 same-cycle write and lookup
    reg_write(8'h78, 32'(2 * 768 + 'h40));
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'hE0; reg_wdata = 32'h99;
    pix_in[2] = 24'h400000; pix_vld_in[2] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; pix_vld_in[2] = 1'b0;
    check("R11 old value on collision", {8'b0, pix_out[2]}, {8'b0, remap(2, 24'h400000)});
    drive_pix(2, 24'h400000);
    check("R11 new value after", {8'b0, pix_out[2]}, {8'h0, 8'h99, tval(2, 1, 0), tval(2, 2, 0)});

    // R8 bypass, valid timing and hold
    reg_write(8'h40, 32'd0);
    drive_pix(0, 24'h123456);
    check("R8 bypass", {8'b0, pix_out[0]}, 32'h00123456);
    @(negedge clk);
    check("R8 vld drop", {31'b0, pix_vld_out[0]}, 32'd0);
    pix_in[0] = 24'hABCDEF;
    @(negedge clk);
    check("R8 hold", {8'b0, pix_out[0]}, 32'h00123456);

    // R12 out of range
    reg_write(8'h78, 32'd2400);
    reg_write(8'hE0, 32'h33);
    reg_read(8'hE0, rd); check("R12 out of range read", rd, 32'd0);

    // R9 keep-powered, then power-down wipe
    reg_write(8'h78, 32'h4000_0064);
    reg_write(8'h44, 32'd0);
    reg_write(8'h48, 32'd0);
    check("R9 keep-powered", {31'b0, sram_en}, 32'd1);
    reg_read(8'hE0, rd); check("R9 contents kept", rd, {24'b0, tval(0, 0, 100)});
    reg_write(8'h78, 32'h0000_0064);
    check("R9 powered down", {31'b0, sram_en}, 32'd0);
    @(negedge clk);
    check("R10 valid dropped", {31'b0, lut_valid}, 32'd0);
    reg_write(8'h40, 32'd1);
    reg_read(8'hE0, rd); check("R9 contents wiped", rd, 32'd0);
    check("R10 still invalid", {31'b0, lut_valid}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule